// File: doc/BRIEF.md
# Guarded-Rule Handshake Stage

This block sits between one upstream producer and one downstream consumer. Both links use a four-phase, return-to-zero request/acknowledge handshake with a data bus beside the request. Inside, a short list of guarded rules is evaluated on every clock edge. A rule's guard is the AND of its triggers: input word present, output slot free, and the test of an internal one-bit state flag. Only the first rule in priority order whose guard holds fires in a cycle. All of its actions take effect on that one clock edge: it acknowledges the input, raises the output request with the new word, and fills or drains the flag.

Two rules are built in. Both move the input word to the output with a constant added. The higher-priority rule also needs the flag to be empty, uses the first constant and fills the flag. The lower-priority rule uses the second constant and drains the flag. Successive words therefore take the two constants in turn. Each link also runs its own return-to-zero cleanup on every edge, whether or not a rule fired.

Top module: `hsre_rule_engine`

## Requirements
- R1: Reset is synchronous with `rst_n` active low. On any edge with `rst_n` low, `in_ack` becomes 1, `out_req` becomes 0, `out_data` becomes 0, and the state flag loads `FLAG_INIT`.
- R2: The input holds a word when `in_req`=1 and `in_ack`=0. When a rule consumes it, `in_ack` reads 1 after the next edge.
- R3: On any edge where `in_ack`=1 and `in_req`=0, `in_ack` returns to 0.
- R4: The output slot is free only when `out_req`=0 and `out_ack`=0, and no rule fires unless it is free. A firing raises `out_req` and loads `out_data` on the same edge that raises `in_ack`.
- R5: On any edge where `out_req`=1 and `out_ack`=1, `out_req` returns to 0. On that edge `out_data` is also cleared to 0 when `KEEP_DATA`=0, which is the default.
- R6: The rule with priority 0 has guard "input holds a word, output free, flag empty". It emits `in_data + ADD_FIRST` modulo 2^DATA_W and fills the flag.
- R7: The rule with priority 1 has guard "input holds a word, output free". It emits `in_data + ADD_SECOND` modulo 2^DATA_W and drains the flag. At most one rule fires per cycle, and rule 0 wins when both guards hold. With `FLAG_INIT`=0, words after reset therefore alternate ADD_FIRST, ADD_SECOND, ADD_FIRST, and so on.
- R8: Every accepted word is emitted exactly once, in arrival order. No output request appears without a consumed input.
- R9: `out_data` holds steady for as long as `out_req` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Upstream request |
| in_ack | output | 1 | Upstream acknowledge |
| in_data | input | DATA_W | Upstream word, valid while in_req is high |
| out_req | output | 1 | Downstream request |
| out_ack | input | 1 | Downstream acknowledge |
| out_data | output | DATA_W | Downstream word |

## Verification
The assertions assume that both neighbours follow the four-phase protocol. The producer raises `in_req` only while `in_ack` is low, keeps it and `in_data` steady until it sees `in_ack` high, and then drops it. The consumer raises `out_ack` only while `out_req` is high and drops it only after `out_req` falls. The bench's producer and consumer tasks keep to these rules by waiting on the opposite handshake line before each transition. They also sweep the gaps between transitions from zero cycles upward, so that cleanup and rule firing meet in every relative order.

// File: rtl/hsre_pkg.sv
package hsre_pkg;

  // Input channel has an unconsumed word.
  function automatic logic chan_holds(input logic req, input logic ack);
    return req & ~ack;
  endfunction

  // Output channel may accept a new word.
  function automatic logic chan_free(input logic req, input logic ack);
    return ~req & ~ack;
  endfunction

  // Output channel handshake completed, request must return to zero.
  function automatic logic chan_done(input logic req, input logic ack);
    return req & ack;
  endfunction

  // Input acknowledge may return to zero.
  function automatic logic chan_released(input logic req, input logic ack);
    return ~req & ack;
  endfunction

endpackage

// File: rtl/hsre_in_port.sv
module hsre_in_port
  import hsre_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic ack,
  output logic holds,
  output logic rtz
);

  assign holds = chan_holds(req, ack);
  assign rtz   = chan_released(req, ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b1;
    end else begin
      if (take) ack <= 1'b1;
      if (rtz)  ack <= 1'b0;
    end
  end

endmodule

// File: rtl/hsre_out_port.sv
module hsre_out_port
  import hsre_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit KEEP_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  output logic              req,
  output logic [DATA_W-1:0] data,
  output logic              free,
  output logic              rtz
);

  assign free = chan_free(req, ack);
  assign rtz  = chan_done(req, ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      if (!KEEP_DATA) data <= '0;
    end else begin
      if (put) begin
        req  <= 1'b1;
        data <= put_data;
      end
      if (rtz) begin
        req <= 1'b0;
        if (!KEEP_DATA) data <= '0;
      end
    end
  end

endmodule

// File: rtl/hsre_flag.sv
module hsre_flag #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fill,
  input  logic drain,
  output logic full
);

  always_ff @(posedge clk) begin
    if (!rst_n)     full <= INIT;
    else if (fill)  full <= 1'b1;
    else if (drain) full <= 1'b0;
  end

endmodule

// File: rtl/hsre_prio.sv
module hsre_prio #(
  parameter int NUM = 2
) (
  input  logic [NUM-1:0] guard,
  output logic [NUM-1:0] fire
);

  logic [NUM:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM; i++) begin : g_chain
    assign fire[i]      = guard[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | guard[i];
  end

endmodule

// File: rtl/hsre_rule_engine.sv
module hsre_rule_engine #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] ADD_FIRST  = 'h11,
  parameter logic [DATA_W-1:0] ADD_SECOND = 'hA5,
  parameter bit                FLAG_INIT  = 1'b0,
  parameter bit                KEEP_DATA  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);

  localparam int NUM_RULES = 2;
  localparam int RULE_MOVE_FIRST  = 0;
  localparam int RULE_MOVE_SECOND = 1;

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  // Named internal events.
  logic                 in_holds, in_rtz;
  logic                 out_free, out_rtz;
  logic                 flag_full;
  logic [NUM_RULES-1:0] guard, fire;
  logic                 consume, emit;
  logic [DATA_W-1:0]    emit_data;

  assign guard[RULE_MOVE_FIRST]  = in_holds & out_free & ~flag_full;
  assign guard[RULE_MOVE_SECOND] = in_holds & out_free;

  hsre_prio #(.NUM(NUM_RULES)) u_prio (
    .guard (guard),
    .fire  (fire)
  );

  assign consume   = |fire;
  assign emit      = |fire;
  assign emit_data = fire[RULE_MOVE_FIRST] ? add_wrap(in_data, ADD_FIRST)
                                           : add_wrap(in_data, ADD_SECOND);

  hsre_in_port u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (in_req),
    .take  (consume),
    .ack   (in_ack),
    .holds (in_holds),
    .rtz   (in_rtz)
  );

  hsre_out_port #(.DATA_W(DATA_W), .KEEP_DATA(KEEP_DATA)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (out_ack),
    .put      (emit),
    .put_data (emit_data),
    .req      (out_req),
    .data     (out_data),
    .free     (out_free),
    .rtz      (out_rtz)
  );

  hsre_flag #(.INIT(FLAG_INIT)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fill  (fire[RULE_MOVE_FIRST]),
    .drain (fire[RULE_MOVE_SECOND]),
    .full  (flag_full)
  );

endmodule

// File: rtl/hsre_checks.sv
module hsre_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        fire,
  input logic              flag_full
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= !rst_n;

  // R1: values loaded by a reset edge
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (in_ack && !out_req)
        else $error("reset state wrong");
    end
  end

  // R2: acknowledge rises only for a present request, together with the output
  p_ack_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> ($past(in_req) && $rose(out_req)));

  // R3: acknowledge returns to zero once request is gone
  p_ack_rtz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !in_req) |=> !in_ack);

  // R4: output written only into a free slot
  p_out_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));

  // R5: output request returns to zero and data clears
  p_out_rtz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> (!out_req && out_data == '0));

  // R6: first rule fills the flag
  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> flag_full);

  // R7: one winner per cycle; second rule drains the flag
  p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> !flag_full);

  // R9: data steady while request is held
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));

endmodule

bind hsre_rule_engine hsre_checks #(.DATA_W(DATA_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_req    (in_req),
  .in_ack    (in_ack),
  .out_req   (out_req),
  .out_ack   (out_ack),
  .out_data  (out_data),
  .fire      (fire),
  .flag_full (flag_full)
);

// File: tb/tb_hsre_rule_engine.sv
`timescale 1ns/1ps
module tb_hsre_rule_engine;

  localparam int         W    = 8;
  localparam logic [7:0] KA   = 8'h11;
  localparam logic [7:0] KB   = 8'hA5;
  localparam int         NSWP = 256;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_req, out_ack;
  logic [W-1:0] in_data;
  logic         in_ack, out_req;
  logic [W-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  hsre_rule_engine #(.DATA_W(W), .ADD_FIRST(KA), .ADD_SECOND(KB)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected word for the k-th transfer after reset (flag starts empty).
  function automatic logic [W-1:0] expect_word(input logic [W-1:0] v, input int k);
    return (k % 2 == 0) ? W'(v + KA) : W'(v + KB);
  endfunction

  task automatic producer();
    for (int v = 0; v < NSWP; v++) begin
      repeat (v % 3) @(negedge clk);
      in_data = W'(v);
      in_req  = 1'b1;
      @(negedge clk);
      while (!in_ack) @(negedge clk);
      repeat ((v / 3) % 2) @(negedge clk);
      in_req = 1'b0;
      @(negedge clk);
      chk("R3 ack return", {31'd0, in_ack}, 32'd0);
    end
  endtask

  task automatic consumer();
    for (int j = 0; j < NSWP; j++) begin
      while (!out_req) @(negedge clk);
      chk("R8 word order/value", {24'd0, out_data}, {24'd0, expect_word(W'(j), j + 2)});
      repeat (j % 4) @(negedge clk);
      out_ack = 1'b1;
      @(negedge clk);
      chk("R5 req return", {31'd0, out_req}, 32'd0);
      chk("R5 data clear", {24'd0, out_data}, 32'd0);
      repeat ((j / 4) % 3) @(negedge clk);
      out_ack = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_req = 1'b0; out_ack = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 in_ack", {31'd0, in_ack}, 32'd1);
    chk("R1 out_req", {31'd0, out_req}, 32'd0);
    chk("R1 out_data", {24'd0, out_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 ack drop after reset", {31'd0, in_ack}, 32'd0);

    // First word: rule 0
    in_data = 8'h3C; in_req = 1'b1;
    @(negedge clk);
    chk("R2 ack raised", {31'd0, in_ack}, 32'd1);
    chk("R4 req with ack", {31'd0, out_req}, 32'd1);
    chk("R6 first constant", {24'd0, out_data}, 32'h4D);
    in_req = 1'b0;
    @(negedge clk);
    chk("R3 ack return", {31'd0, in_ack}, 32'd0);
    chk("R9 req held", {31'd0, out_req}, 32'd1);

    // Second word waits on a busy output
    in_data = 8'hF0; in_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 busy slot blocks", {31'd0, in_ack}, 32'd0);
    chk("R9 data steady", {24'd0, out_data}, 32'h4D);
    out_ack = 1'b1;
    @(negedge clk);
    chk("R5 req return", {31'd0, out_req}, 32'd0);
    chk("R5 data clear", {24'd0, out_data}, 32'd0);
    chk("R4 ack high blocks", {31'd0, in_ack}, 32'd0);
    out_ack = 1'b0;
    @(negedge clk);
    chk("R7 second rule ack", {31'd0, in_ack}, 32'd1);
    chk("R7 second rule req", {31'd0, out_req}, 32'd1);
    chk("R7 second constant", {24'd0, out_data}, 32'h95);
    in_req = 1'b0; out_ack = 1'b1;
    @(negedge clk);
    chk("R3 ack return", {31'd0, in_ack}, 32'd0);
    chk("R5 req return", {31'd0, out_req}, 32'd0);
    out_ack = 1'b0;
    @(negedge clk);

    // Sweep all word values under varied handshake gaps
    fork
      producer();
      consumer();
    join
    repeat (10) @(negedge clk);
    chk("R8 no extra word", {31'd0, out_req}, 32'd0);
    chk("R8 input idle", {31'd0, in_ack}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule